// File: doc/BRIEF.md
# Dual Status Register Fault Manager

This block holds the fault state of a multi-channel output driver as two 16-bit status images. One image gathers the protective faults: a per-driver overcurrent flag, thermal shutdown, and the supply under- and overvoltage flags. The other gathers the diagnostic faults: a per-driver open-load flag, thermal warning and charge pump off. Both images carry a constant-one marker in the top bit and an active-high "all clear" summary in bit 0, so a serial front end can shift either image out without further work.

Fault inputs are one-cycle event pulses, apart from the two supply inputs, which are live levels. The latched protective faults produce a per-driver disable mask and a global disable. The serial front end supplies two bits from the committed command word and a strobe at the end of each frame. One bit selects whether supply faults latch or recover on their own. The other asks for all flags to be cleared at that frame's end. The front end shifts out the current frame's status before this strobe arrives.

Top module: `fault_status_mgr`

## Requirements
- R1: After reset both images read 16'h8001, `drv_off` is all zeros and `all_off` is 0.
- R2: In `stat0`, bit 1+i is the overcurrent flag of driver i (i = 0..10), bit 12 is thermal shutdown, bit 13 is supply undervoltage and bit 14 is supply overvoltage.
- R3: In `stat1`, bit 1+i is the open-load flag of driver i, bit 12 is thermal warning, bit 13 is charge pump off and bit 14 always reads 0.
- R4: Bit 15 of both images always reads 1. Bit 0 of both images is 1 exactly when bits 1 to 14 of both images are all 0.
- R5: An event pulse sampled at a rising clock edge sets its flag in that edge. Overcurrent, open-load, thermal and charge pump flags then stay set until a clear.
- R6: `drv_off[i]` equals the overcurrent flag of driver i. No other flag drives any bit of `drv_off`.
- R7: While the thermal shutdown flag is set, `all_off` is 1.
- R8: With `lockout_cmd` = 1, a supply level of 1 sets its flag. The flag and `all_off` stay set after the level returns to 0, until a clear.
- R9: With `lockout_cmd` = 0, each supply flag takes the value of its live level at every edge. `all_off` falls one edge after the supply returns to range, unless another cause holds it.
- R10: An edge with both `frame_commit` and `clear_cmd` at 1 clears every flag. Either input alone leaves all flags unchanged.
- R11: An event pulse at the same edge as a clear wins, and its flag stays set.
- R12: With `lockout_cmd` = 1, a supply level still at 1 during a clear keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_evt | input | 11 | Overcurrent event pulse, one per driver |
| ol_evt | input | 11 | Open-load event pulse, one per driver |
| tsd_evt | input | 1 | Thermal shutdown event pulse |
| twarn_evt | input | 1 | Thermal warning event pulse |
| cp_off_evt | input | 1 | Charge pump off event pulse |
| sup_uv | input | 1 | Live supply undervoltage level |
| sup_ov | input | 1 | Live supply overvoltage level |
| lockout_cmd | input | 1 | Committed command bit: 1 latches supply faults |
| clear_cmd | input | 1 | Committed command bit: clear all flags at frame end |
| frame_commit | input | 1 | One-cycle strobe at the end of a frame |
| stat0 | output | 16 | Protective status image |
| stat1 | output | 16 | Diagnostic status image |
| drv_off | output | 11 | Per-driver disable mask |
| all_off | output | 1 | Disable for all drivers |

## Verification
Every flag is a register that samples its inputs at the rising edge. All four outputs are combinational from those registers, so every result is due one edge after the stimulus that causes it. The bench drives stimulus at a falling edge and steps its own model of the flags just after the next rising edge. It compares all outputs at the following falling edge, half a period after the design settles. Pulses are withdrawn only after that comparison. Held states, such as latched supply faults and sticky flags, are rechecked at several later edges.

// File: rtl/fm_pkg.sv
package fm_pkg;
   localparam int IMG_W      = 16;
   localparam int BIT_OK     = 0;
   localparam int BIT_DRV0   = 1;
   localparam int BIT_THERM  = 12;
   localparam int BIT_SUP_LO = 13;
   localparam int BIT_SUP_HI = 14;
   localparam int BIT_ONE    = 15;
   localparam int NUM_SUP    = 2;

   typedef enum logic {
      SUP_AUTO = 1'b0,
      SUP_HOLD = 1'b1
   } sup_mode_e;
endpackage

// File: rtl/fm_sticky_bank.sv
module fm_sticky_bank #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         clr,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("fm_sticky_bank: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (clr ? '0 : q) | set;
   end

   // R5: without a clear, no set flag drops
   a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((q & $past(q)) == $past(q)));

   // R11: a pulse always leaves its flag set, clear or not
   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/fm_supply_flag.sv
module fm_supply_flag
   import fm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      level,
   input  sup_mode_e mode,
   input  logic      clr,
   output logic      flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag <= 1'b0;
      else if (mode == SUP_HOLD) flag <= (flag & ~clr) | level;
      else                       flag <= level;
   end

   // R9: in auto mode the flag tracks the live level one edge later
   a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SUP_AUTO) |=> (flag == $past(level)));

   // R8: in hold mode a set flag survives until a clear
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SUP_HOLD && flag && !clr) |=> flag);

   // R12: in hold mode a level still present at a clear keeps the flag
   a_r12_level_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SUP_HOLD && level) |=> flag);
endmodule

// File: rtl/fm_image_pack.sv
module fm_image_pack
   import fm_pkg::*;
#(
   parameter int NUM_DRV = 11
) (
   input  logic [NUM_DRV-1:0] oc,
   input  logic [NUM_DRV-1:0] ol,
   input  logic               tsd,
   input  logic               twarn,
   input  logic               cp_off,
   input  logic               uv,
   input  logic               ov,
   output logic [IMG_W-1:0]   img0,
   output logic [IMG_W-1:0]   img1
);
   localparam int FLAG_BITS = BIT_SUP_HI - BIT_OK;

   logic [FLAG_BITS-1:0] body0, body1;
   logic                 none;

   always_comb begin
      body0 = '0;
      body1 = '0;
      for (int i = 0; i < NUM_DRV; i++) begin
         body0[BIT_DRV0 + i - 1] = oc[i];
         body1[BIT_DRV0 + i - 1] = ol[i];
      end
      body0[BIT_THERM  - 1] = tsd;
      body0[BIT_SUP_LO - 1] = uv;
      body0[BIT_SUP_HI - 1] = ov;
      body1[BIT_THERM  - 1] = twarn;
      body1[BIT_SUP_LO - 1] = cp_off;
      body1[BIT_SUP_HI - 1] = 1'b0;
      none = ~(|body0 | |body1);
      img0 = {1'b1, body0, none};
      img1 = {1'b1, body1, none};
   end
endmodule

// File: rtl/fault_status_mgr.sv
module fault_status_mgr
   import fm_pkg::*;
#(
   parameter int NUM_DRV = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DRV-1:0] oc_evt,
   input  logic [NUM_DRV-1:0] ol_evt,
   input  logic               tsd_evt,
   input  logic               twarn_evt,
   input  logic               cp_off_evt,
   input  logic               sup_uv,
   input  logic               sup_ov,
   input  logic               lockout_cmd,
   input  logic               clear_cmd,
   input  logic               frame_commit,
   output logic [15:0]        stat0,
   output logic [15:0]        stat1,
   output logic [NUM_DRV-1:0] drv_off,
   output logic               all_off
);
   localparam int MISC_W = 3;

   if (NUM_DRV != BIT_THERM - BIT_DRV0) begin : g_bad_drv
      $error("fault_status_mgr: NUM_DRV must fill image bits 1 to 11");
   end
   if (IMG_W != 16) begin : g_bad_img
      $error("fault_status_mgr: image width must be 16");
   end

   logic               clr_now;
   logic [NUM_DRV-1:0] oc_q, ol_q;
   logic [MISC_W-1:0]  misc_q;
   logic [NUM_SUP-1:0] sup_lvl, sup_q;
   sup_mode_e          sup_mode;

   assign clr_now  = frame_commit & clear_cmd;
   assign sup_mode = lockout_cmd ? SUP_HOLD : SUP_AUTO;
   assign sup_lvl  = {sup_ov, sup_uv};

   fm_sticky_bank #(.W(NUM_DRV)) u_oc (
      .clk(clk), .rst_n(rst_n), .set(oc_evt), .clr(clr_now), .q(oc_q));

   fm_sticky_bank #(.W(NUM_DRV)) u_ol (
      .clk(clk), .rst_n(rst_n), .set(ol_evt), .clr(clr_now), .q(ol_q));

   fm_sticky_bank #(.W(MISC_W)) u_misc (
      .clk(clk), .rst_n(rst_n), .set({cp_off_evt, twarn_evt, tsd_evt}),
      .clr(clr_now), .q(misc_q));

   for (genvar k = 0; k < NUM_SUP; k++) begin : g_sup
      fm_supply_flag u_flag (
         .clk(clk), .rst_n(rst_n), .level(sup_lvl[k]), .mode(sup_mode),
         .clr(clr_now), .flag(sup_q[k]));
   end

   fm_image_pack #(.NUM_DRV(NUM_DRV)) u_pack (
      .oc(oc_q), .ol(ol_q), .tsd(misc_q[0]), .twarn(misc_q[1]),
      .cp_off(misc_q[2]), .uv(sup_q[0]), .ov(sup_q[1]),
      .img0(stat0), .img1(stat1));

   assign drv_off = oc_q;
   assign all_off = misc_q[0] | (|sup_q);

   // R7: a thermal shutdown pulse turns all drivers off at the next edge
   a_r7_tsd_off: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_evt |=> all_off);

   // R6: an overcurrent pulse disables its own driver
   a_r6_oc_off: assert property (@(posedge clk) disable iff (!rst_n)
      (|oc_evt) |=> ((drv_off & $past(oc_evt)) == $past(oc_evt)));

   // R10: a clear with no new overcurrent frees every driver
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_commit && clear_cmd && oc_evt == '0) |=> (drv_off == '0));

   // R4: summary bits of both images agree
   a_r4_summary_match: assert property (@(posedge clk) disable iff (!rst_n)
      stat0[0] == stat1[0]);
endmodule

// File: tb/fault_status_mgr_test.sv
`timescale 1ns/1ps
module fault_status_mgr_test;
   localparam int N = 11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] oc_evt = '0, ol_evt = '0;
   logic         tsd_evt = 0, twarn_evt = 0, cp_off_evt = 0;
   logic         sup_uv = 0, sup_ov = 0, lockout_cmd = 0;
   logic         clear_cmd = 0, frame_commit = 0;
   logic [15:0]  stat0, stat1;
   logic [N-1:0] drv_off;
   logic         all_off;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // bench model of the flags
   logic [N-1:0] m_oc = '0, m_ol = '0;
   logic m_tsd = 0, m_tw = 0, m_cp = 0, m_uv = 0, m_ov = 0;

   always #2.5 clk = ~clk;

   fault_status_mgr #(.NUM_DRV(N)) uut (
      .clk(clk), .rst_n(rst_n), .oc_evt(oc_evt), .ol_evt(ol_evt),
      .tsd_evt(tsd_evt), .twarn_evt(twarn_evt), .cp_off_evt(cp_off_evt),
      .sup_uv(sup_uv), .sup_ov(sup_ov), .lockout_cmd(lockout_cmd),
      .clear_cmd(clear_cmd), .frame_commit(frame_commit),
      .stat0(stat0), .stat1(stat1), .drv_off(drv_off), .all_off(all_off));

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      logic none;
      logic [15:0] e0, e1;
      none = ~(|m_oc | |m_ol | m_tsd | m_tw | m_cp | m_uv | m_ov);
      e0 = {1'b1, m_ov, m_uv, m_tsd, m_oc, none};
      e1 = {1'b1, 1'b0, m_cp, m_tw, m_ol, none};
      chk(tag, "stat0", stat0, e0);
      chk(tag, "stat1", stat1, e1);
      chk(tag, "drv_off", {5'd0, drv_off}, {5'd0, m_oc});
      chk(tag, "all_off", {15'd0, all_off}, {15'd0, m_tsd | m_uv | m_ov});
   endtask

   // one clock: model steps after the edge, outputs compared at the falling edge
   task automatic step(string tag);
      logic clr;
      @(posedge clk);
      #1;
      clr   = frame_commit & clear_cmd;
      m_oc  = (clr ? '0 : m_oc) | oc_evt;
      m_ol  = (clr ? '0 : m_ol) | ol_evt;
      m_tsd = (m_tsd & ~clr) | tsd_evt;
      m_tw  = (m_tw & ~clr) | twarn_evt;
      m_cp  = (m_cp & ~clr) | cp_off_evt;
      m_uv  = lockout_cmd ? ((m_uv & ~clr) | sup_uv) : sup_uv;
      m_ov  = lockout_cmd ? ((m_ov & ~clr) | sup_ov) : sup_ov;
      @(negedge clk);
      check_all(tag);
      oc_evt = '0; ol_evt = '0; tsd_evt = 0; twarn_evt = 0; cp_off_evt = 0;
      frame_commit = 0; clear_cmd = 0;
   endtask

   task automatic do_clear(string tag);
      frame_commit = 1; clear_cmd = 1;
      step(tag);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "stat0", stat0, 16'h8001);
      chk("R1", "stat1", stat1, 16'h8001);
      chk("R1", "drv_off", {5'd0, drv_off}, 16'h0000);
      chk("R1", "all_off", {15'd0, all_off}, 16'h0000);
      rst_n = 1;
      @(negedge clk);
      check_all("R1");

      // R2 / R6: each overcurrent flag and its own driver
      for (int i = 0; i < N; i++) begin
         oc_evt = N'(1) << i;
         step("R2");
         chk("R6", "drv_off one-hot", {5'd0, drv_off}, 16'(1) << i);
         chk("R2", "stat0 position", stat0, 16'h8000 | (16'(1) << (i + 1)));
         do_clear("R10");
      end

      // R3 / R6: open load sets stat1 and never disables
      for (int i = 0; i < N; i++) begin
         ol_evt = N'(1) << i;
         step("R3");
         chk("R6", "drv_off open-load", {5'd0, drv_off}, 16'h0000);
         chk("R3", "stat1 position", stat1, 16'h8000 | (16'(1) << (i + 1)));
         do_clear("R10");
      end

      // R4 / R5: every overcurrent/open-load pair, summary and stickiness
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            oc_evt = N'(1) << i;
            step("R5");
            ol_evt = N'(1) << j;
            step("R4");
            chk("R4", "summary bit", {15'd0, stat0[0] | stat1[0]}, 16'h0000);
            do_clear("R4");
            chk("R4", "summary restored", stat1, 16'h8001);
         end
      end

      // R7 / R10: thermal shutdown held, partial clears ignored
      tsd_evt = 1;
      step("R7");
      repeat (3) step("R5");
      frame_commit = 1;
      step("R10");
      clear_cmd = 1;
      step("R10");
      chk("R7", "all_off held", {15'd0, all_off}, 16'h0001);
      do_clear("R10");
      chk("R7", "all_off cleared", {15'd0, all_off}, 16'h0000);

      // R3 / R5: thermal warning and charge pump in stat1
      twarn_evt = 1;
      step("R3");
      cp_off_evt = 1;
      step("R3");
      repeat (2) step("R5");
      chk("R3", "stat1 warn+cp", stat1, 16'h b000);
      chk("R3", "all_off from diag", {15'd0, all_off}, 16'h0000);
      do_clear("R10");

      // R8: latched supply faults
      lockout_cmd = 1;
      sup_uv = 1;
      repeat (2) step("R8");
      sup_uv = 0;
      repeat (3) step("R8");
      chk("R8", "uv latched", stat0, 16'h a000);
      do_clear("R8");
      sup_ov = 1;
      step("R8");
      sup_ov = 0;
      repeat (2) step("R8");
      chk("R8", "ov all_off", {15'd0, all_off}, 16'h0001);
      do_clear("R8");

      // R12: level still present during clear
      sup_ov = 1;
      step("R12");
      do_clear("R12");
      chk("R12", "ov survives clear", stat0, 16'h c000);
      sup_ov = 0;
      step("R12");
      do_clear("R12");

      // R9: auto-recovery, including leaving lockout with a stale flag
      lockout_cmd = 0;
      sup_uv = 1;
      repeat (2) step("R9");
      sup_uv = 0;
      step("R9");
      chk("R9", "all_off recovered", {15'd0, all_off}, 16'h0000);
      lockout_cmd = 1;
      sup_ov = 1;
      step("R9");
      sup_ov = 0;
      step("R9");
      lockout_cmd = 0;
      step("R9");
      chk("R9", "stale flag drops", stat0, 16'h8001);

      // R11: event at the clear edge wins
      for (int i = 0; i < N; i++) begin
         oc_evt = '1;
         step("R11");
         oc_evt = N'(1) << i;
         frame_commit = 1; clear_cmd = 1;
         step("R11");
         chk("R11", "only new flag", {5'd0, drv_off}, 16'(1) << i);
         do_clear("R11");
      end
      tsd_evt = 1; frame_commit = 1; clear_cmd = 1;
      step("R11");
      do_clear("R11");

      done = 1;
      summary();
      $finish;
   end
endmodule